// File: doc/BRIEF.md
# Asynchronous Bus Capture Interface

This block takes transfers from a parallel bus that has no timing relationship to the internal clock and hands them to clocked logic. The address is held in a level-sensitive latch that is open while the address latch enable is high and closes when it falls. The data is held in a second latch that is open while the data strobe is low and closes when the strobe rises. Neither latch is clocked.

The data strobe is the last signal the bus asserts. It is the only input that crosses into the clock domain, through a chain of flip-flops. Once the synchronized strobe is high, both latches have been closed for several clock cycles and their contents are settled. A rising edge of the synchronized strobe copies both latches into clocked output registers and raises a valid flag for exactly one cycle. No address or data bit is ever synchronized on its own.

Top module: `async_bus_capture`

## Requirements
- R1: The address latch is transparent while `ale_i` is high and holds its value after `ale_i` falls. Later changes on `addr_i` while `ale_i` is low do not reach `addr_o`.
- R2: The data latch is transparent while `dstb_i` is low and holds the value present when `dstb_i` rises. Changes on `data_i` while `dstb_i` is high do not reach `data_o`.
- R3: Take `dstb_i` as sampled high first at clock edge 1. Then `valid_o` is high after edge SYNC_STAGES+1 (edge 3 with the default of 2) and low after the edges before it.
- R4: Each low-to-high transition of `dstb_i` that is held for at least SYNC_STAGES+2 cycles gives exactly one cycle of `valid_o`, however long the strobe stays high. `valid_o` is never high on two consecutive cycles.
- R5: `addr_o` and `data_o` take the latched values on the same edge that raises `valid_o`. They keep those values until the next `valid_o`, including while `dstb_i` is low and the data latch is open again.
- R6: While `rst` (synchronous, active high) is high, and on the first cycle after it, `valid_o` is 0 and `addr_o` and `data_o` are 0.
- R7: If `dstb_i` is high when `rst` is released, no `valid_o` occurs until `dstb_i` has gone low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset, used only for initialization |
| ale_i | input | 1 | Address latch enable from the bus (latch transparent while high) |
| addr_i | input | ADDR_W | Bus address |
| dstb_i | input | 1 | Data strobe from the bus, the last asserted signal |
| data_i | input | DATA_W | Bus data |
| valid_o | output | 1 | One-cycle pulse marking a new transfer |
| addr_o | output | ADDR_W | Captured address, held between transfers |
| data_o | output | DATA_W | Captured data, held between transfers |

## Verification
Embedded properties check on every cycle that the valid flag never lasts two cycles and that it only follows a low-then-high history of the synchronized strobe. They also check that the outputs move only when the flag is raised, and that the block is idle right after reset. The bench scenarios are the only way to show that the values on the outputs are the ones presented while each latch was open, and not values that changed afterwards. The same holds for the exact synchronizer latency, for one pulse per strobe of any length, and for a strobe that is already high when reset is released. Random transfers with varied strobe and gap lengths are mixed with directed latency and reset cases.

// File: rtl/abc_pkg.sv
package abc_pkg;

    localparam int unsigned DEF_ADDR_W      = 16;
    localparam int unsigned DEF_DATA_W      = 32;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Rising edge between the previous and current synchronized level.
    function automatic logic rise_seen(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/abc_level_latch.sv
module abc_level_latch #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             open_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    // Transparent while open_i is high, holds once it drops.
    always_latch begin
        if (open_i) begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/abc_strobe_sync.sv
module abc_strobe_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic level_o
);

    logic [STAGES-1:0] chain_q;

    // Chain resets to all ones, so a strobe already high at reset release
    // never looks like a fresh rising edge.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b1;
                    else     chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b1;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign level_o = chain_q[STAGES-1];

endmodule

// File: rtl/async_bus_capture.sv
module async_bus_capture
    import abc_pkg::*;
#(
    parameter int unsigned ADDR_W      = DEF_ADDR_W,
    parameter int unsigned DATA_W      = DEF_DATA_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              dstb_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    logic [ADDR_W-1:0] addr_held;
    logic [DATA_W-1:0] data_held;
    logic              data_open;
    logic              strb_level;
    logic              strb_prev_q;
    logic              take;

    assign data_open = ~dstb_i;

    abc_level_latch #(.WIDTH(ADDR_W)) i_addr_latch (
        .open_i (ale_i),
        .d_i    (addr_i),
        .q_o    (addr_held)
    );

    abc_level_latch #(.WIDTH(DATA_W)) i_data_latch (
        .open_i (data_open),
        .d_i    (data_i),
        .q_o    (data_held)
    );

    abc_strobe_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (dstb_i),
        .level_o (strb_level)
    );

    assign take = rise_seen(strb_level, strb_prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            strb_prev_q <= 1'b1;
            valid_o     <= 1'b0;
            addr_o      <= '0;
            data_o      <= '0;
        end else begin
            strb_prev_q <= strb_level;
            valid_o     <= take;
            if (take) begin
                addr_o <= addr_held;
                data_o <= data_held;
            end
        end
    end

    // R4: the transfer flag never stretches over two cycles.
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R3 / R7: a flag needs the synchronized strobe low, then high.
    p_edge_source_r3: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ($past(strb_level, 1) && !$past(strb_level, 2)));

    // R5: captured outputs only move together with the flag.
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(addr_o) && $stable(data_o)));

    // R6: idle and cleared on the first cycle after reset.
    p_idle_after_reset_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!valid_o && addr_o == '0 && data_o == '0));

endmodule

// File: tb/test_async_bus_capture.sv
module test_async_bus_capture;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned ADDR_W     = 16;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned STAGES     = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ale_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic              dstb_i = 1'b0;
    logic [DATA_W-1:0] data_i = '0;
    logic              valid_o;
    logic [ADDR_W-1:0] addr_o;
    logic [DATA_W-1:0] data_o;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    async_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(STAGES))
        i_async_bus_capture (
        .clk(clk), .rst(rst), .ale_i(ale_i), .addr_i(addr_i),
        .dstb_i(dstb_i), .data_i(data_i),
        .valid_o(valid_o), .addr_o(addr_o), .data_o(data_o)
    );

    always @(negedge clk) if (!rst && valid_o) pulses++;

    // Expected flag level k negedges after the strobe is raised at a negedge.
    function automatic logic exp_valid(input int k);
        return (k == int'(STAGES) + 1);
    endfunction

    function automatic int rand_range(input int lo, input int hi);
        return lo + int'($urandom % (hi - lo + 1));
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // One bus transfer; scrambles the buses after each latch closes.
    task automatic transfer(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input int hold, input int gap);
        int p0;
        addr_i = a; ale_i = 1'b1;
        tick(1);
        ale_i = 1'b0;
        addr_i = ADDR_W'($urandom);
        data_i = d;
        tick(1);
        p0 = pulses;
        dstb_i = 1'b1;
        #1 data_i = DATA_W'($urandom);
        tick(hold);
        check("R4 one pulse during strobe", pulses - p0, 1);
        check("R1 address held after ale fall", addr_o, a);
        check("R2 data held while strobe high", data_o, d);
        dstb_i = 1'b0;
        #1 data_i = DATA_W'($urandom);
        addr_i = ADDR_W'($urandom);
        tick(gap + 3);
        check("R4 no pulse on strobe fall", pulses - p0, 1);
        check("R5 outputs held between transfers", {addr_o, data_o}, {a, d});
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        tick(3);
        check("R6 valid in reset", valid_o, 0);
        check("R6 address in reset", addr_o, 0);
        check("R6 data in reset", data_o, 0);
        rst = 1'b0;
        tick(1);
        check("R6 idle after reset", {valid_o, addr_o, data_o}, 0);
        tick(3);
        check("R6 no spontaneous pulse", pulses, 0);

        // R3: directed latency.
        addr_i = 16'hA5C3; ale_i = 1'b1; tick(1); ale_i = 1'b0;
        data_i = 32'h1234_5678; tick(1);
        dstb_i = 1'b1;
        for (int k = 1; k <= int'(STAGES) + 3; k++) begin
            tick(1);
            check($sformatf("R3 latency cycle %0d", k), valid_o, exp_valid(k));
            if (exp_valid(k))
                check("R5 outputs with pulse", {addr_o, data_o}, {16'hA5C3, 32'h1234_5678});
        end
        dstb_i = 1'b0;
        tick(5);

        // Directed corners: all-ones, all-zeros, long strobe.
        transfer('1, '1, 4, 1);
        transfer('0, '0, 4, 1);
        transfer(16'h8001, 32'h8000_0001, 40, 2);

        // Random transfers.
        for (int i = 0; i < 40; i++)
            transfer(ADDR_W'($urandom), DATA_W'($urandom),
                     rand_range(int'(STAGES) + 2, 12), rand_range(0, 6));

        // R7: strobe high across reset release.
        begin
            int p0;
            dstb_i = 1'b1;
            rst = 1'b1;
            tick(3);
            p0 = pulses;
            rst = 1'b0;
            tick(10);
            check("R7 no pulse with strobe high at reset release", pulses - p0, 0);
            check("R6 outputs cleared by reset", {addr_o, data_o}, 0);
            dstb_i = 1'b0;
            tick(5);
            check("R7 no pulse on first strobe fall", pulses - p0, 0);
        end
        transfer(16'h0F0F, 32'hCAFE_F00D, 6, 2);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule